// File: doc/BRIEF.md
# Power Mode Sequencer

This block holds a byte-wide control/status register and a small sequencer that moves a device between four operating modes: Active, Power Save, Idle and Halt. Software writes the register to ask for a low-power mode. The request either starts a switch at once or is held until the processor signals that it has executed its wait instruction. The switch then runs for a fixed number of slow-clock ticks, which stands for the clock system's acknowledge. Only after that do the mode output and the matching status bit change.

A hardware wake-up event always returns the device to Active. It clears any status bit, cancels a request that is still pending and aborts a switch that is in progress. Three clock-enable outputs (system, main, slow) follow the current mode. The five upper register bits are plain storage, read by the oscillator and PLL arbitration block.

Top module: `pms_seq`

## Requirements
- R1: After reset, rd_data reads 0x00, mode_o is 0 (Active) and all three clock enables are 1.
- R2: Bits 7:3 of every write are stored and read back unchanged in rd_data[7:3]. Bit 3 is the defer bit.
- R3: In Active with nothing pending, a write with bit 0 = 1 and bit 3 = 0 starts a Power Save switch at once. mode_o becomes 1 and rd_data[0] becomes 1 on the edge that samples the SW_LAT-th slow_tick after the write, and not before.
- R4: A write with bit 0 = 1 and bit 3 = 1 leaves a pending request. Slow ticks do not advance it. The switch starts at the next wait_stb and completes SW_LAT ticks later.
- R5: Idle (bit 1) and Halt (bit 2) requests are honoured only when bit 3 is 1 in the same write, and they always wait for wait_stb. Without bit 3 they are ignored.
- R6: When several of bits 2:0 are set in one honoured write, Halt (mode_o 3) wins over Idle (mode_o 2), and Idle wins over Power Save (mode_o 1).
- R7: wait_stb with no pending request has no effect.
- R8: The clock enables are {sys,main,slow} = 111 in Active and Power Save and while a request is pending or switching, 011 in Idle, and 000 in Halt.
- R9: wake_evt returns mode_o to 0 and clears rd_data[2:0] on the next edge. It cancels a pending request, aborts a running switch, and wins over a wait_stb or a switch completion in the same cycle.
- R10: In a low-power mode, a write whose bit for the current mode is 0 returns to Active, and a write that keeps that bit at 1 leaves the mode unchanged. While a request is pending or switching, a write with bits 2:0 = 0 cancels it.
- R11: rd_data[2:0] has at most one bit set: bit 0 for Power Save, bit 1 for Idle, bit 2 for Halt, matching mode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value (stored bits 7:3, mode status 2:0) |
| wait_stb | input | 1 | Processor executed its wait instruction |
| wake_evt | input | 1 | Hardware wake-up event |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| mode_o | output | 2 | Current mode: 0 Active, 1 Power Save, 2 Idle, 3 Halt |
| sys_clk_en | output | 1 | System clock enable |
| main_clk_en | output | 1 | Main clock enable |
| slow_clk_en | output | 1 | Slow clock enable |

## Verification
A wake-up can land in the same cycle as a wait strobe that would start a deferred switch, or in the same cycle as the slow tick that would finish a switch. The bench drives each pair on one clock edge. It then gives the full switch latency in further ticks plus one more wait strobe. The mode must read Active throughout, which shows that the wake-up won and that the request was discarded, not merely delayed.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [1:0] {
        MODE_ACT = 2'd0,
        MODE_PSV = 2'd1,
        MODE_IDL = 2'd2,
        MODE_HLT = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_PEND = 2'd1,
        PH_SWCH = 2'd2
    } phase_e;

    localparam int CFG_W = 5;

    typedef struct packed {
        mode_e              mode;
        phase_e             phase;
        mode_e              target;
        logic [CFG_W-1:0]   cfg;
    } seq_state_t;

endpackage

// File: rtl/pms_req_decode.sv
module pms_req_decode
    import pms_pkg::*;
(
    input  logic [7:0] wr_data,
    output logic       req_valid,
    output logic       req_defer,
    output mode_e      req_mode
);
    logic defer_bit;
    assign defer_bit = wr_data[3];

    always_comb begin
        req_valid = 1'b0;
        req_defer = 1'b0;
        req_mode  = MODE_ACT;
        if (defer_bit) begin
            if (wr_data[2]) begin
                req_valid = 1'b1;
                req_defer = 1'b1;
                req_mode  = MODE_HLT;
            end else if (wr_data[1]) begin
                req_valid = 1'b1;
                req_defer = 1'b1;
                req_mode  = MODE_IDL;
            end else if (wr_data[0]) begin
                req_valid = 1'b1;
                req_defer = 1'b1;
                req_mode  = MODE_PSV;
            end
        end else if (wr_data[0]) begin
            req_valid = 1'b1;
            req_defer = 1'b0;
            req_mode  = MODE_PSV;
        end
    end
endmodule

// File: rtl/pms_switch_timer.sv
module pms_switch_timer #(
    parameter int SW_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (SW_LAT < 2) ? 1 : $clog2(SW_LAT);
    localparam logic [CW-1:0] LAST = CW'(SW_LAT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/pms_clk_map.sv
module pms_clk_map
    import pms_pkg::*;
(
    input  mode_e mode,
    output logic  sys_en,
    output logic  main_en,
    output logic  slow_en
);
    always_comb begin
        unique case (mode)
            MODE_IDL: {sys_en, main_en, slow_en} = 3'b011;
            MODE_HLT: {sys_en, main_en, slow_en} = 3'b000;
            default:  {sys_en, main_en, slow_en} = 3'b111;
        endcase
    end
endmodule

// File: rtl/pms_seq.sv
module pms_seq
    import pms_pkg::*;
#(
    parameter int SW_LAT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       wait_stb,
    input  logic       wake_evt,
    input  logic       slow_tick,
    output logic [1:0] mode_o,
    output logic       sys_clk_en,
    output logic       main_clk_en,
    output logic       slow_clk_en
);
    seq_state_t st_d, st_q;

    logic  req_valid, req_defer, sw_done;
    mode_e req_mode;
    logic  cur_bit;

    pms_req_decode u_dec (
        .wr_data   (wr_data),
        .req_valid (req_valid),
        .req_defer (req_defer),
        .req_mode  (req_mode)
    );

    pms_switch_timer #(.SW_LAT(SW_LAT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.phase == PH_SWCH),
        .tick  (slow_tick),
        .done  (sw_done)
    );

    pms_clk_map u_map (
        .mode    (st_q.mode),
        .sys_en  (sys_clk_en),
        .main_en (main_clk_en),
        .slow_en (slow_clk_en)
    );

    always_comb begin
        unique case (st_q.mode)
            MODE_PSV: cur_bit = wr_data[0];
            MODE_IDL: cur_bit = wr_data[1];
            MODE_HLT: cur_bit = wr_data[2];
            default:  cur_bit = 1'b1;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.cfg = wr_data[7:3];
        if (wake_evt) begin
            st_d.mode  = MODE_ACT;
            st_d.phase = PH_RUN;
        end else begin
            unique case (st_q.phase)
                PH_RUN: begin
                    if (st_q.mode == MODE_ACT) begin
                        if (wr_en && req_valid) begin
                            st_d.target = req_mode;
                            st_d.phase  = req_defer ? PH_PEND : PH_SWCH;
                        end
                    end else if (wr_en && !cur_bit) begin
                        st_d.mode = MODE_ACT;
                    end
                end
                PH_PEND: begin
                    if (wr_en && wr_data[2:0] == 3'b000) st_d.phase = PH_RUN;
                    else if (wait_stb)                  st_d.phase = PH_SWCH;
                end
                PH_SWCH: begin
                    if (wr_en && wr_data[2:0] == 3'b000) begin
                        st_d.phase = PH_RUN;
                    end else if (sw_done) begin
                        st_d.mode  = st_q.target;
                        st_d.phase = PH_RUN;
                    end
                end
                default: st_d.phase = PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_ACT;
            st_q.phase  <= PH_RUN;
            st_q.target <= MODE_ACT;
            st_q.cfg    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign rd_data = {st_q.cfg,
                      st_q.mode == MODE_HLT,
                      st_q.mode == MODE_IDL,
                      st_q.mode == MODE_PSV};
endmodule

// File: rtl/pms_seq_chk.sv
module pms_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_evt,
    input logic       slow_tick,
    input logic [1:0] mode_o,
    input logic [7:0] rd_data,
    input logic       sys_clk_en,
    input logic       main_clk_en,
    input logic       slow_clk_en
);
    a_r8_halt_gates_all: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> (!sys_clk_en && !main_clk_en && !slow_clk_en));

    a_r8_idle_keeps_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (!sys_clk_en && main_clk_en && slow_clk_en));

    a_r9_wake_to_active: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> (mode_o == 2'd0 && rd_data[2:0] == 3'b000));

    a_r11_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_data[2:0]));

    a_r3_entry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[0]) |-> $past(slow_tick));

    a_r10_exit_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o) && $past(mode_o) != 2'd0) |-> (mode_o == 2'd0));
endmodule

bind pms_seq pms_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_evt    (wake_evt),
    .slow_tick   (slow_tick),
    .mode_o      (mode_o),
    .rd_data     (rd_data),
    .sys_clk_en  (sys_clk_en),
    .main_clk_en (main_clk_en),
    .slow_clk_en (slow_clk_en)
);

// File: tb/pms_seq_tb.sv
module pms_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       wait_stb = 1'b0;
    logic       wake_evt = 1'b0;
    logic       slow_tick = 1'b0;
    logic [1:0] mode_o;
    logic       sys_clk_en, main_clk_en, slow_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pms_seq #(.SW_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wait_stb(wait_stb), .wake_evt(wake_evt),
        .slow_tick(slow_tick), .mode_o(mode_o), .sys_clk_en(sys_clk_en),
        .main_clk_en(main_clk_en), .slow_clk_en(slow_clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock with the given inputs; outputs sampled at the following negedge
    task automatic step(input bit we, input logic [7:0] d, input bit ws,
                        input bit wk, input bit tk);
        @(negedge clk);
        wr_en = we; wr_data = d; wait_stb = ws; wake_evt = wk; slow_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; wait_stb = 1'b0; wake_evt = 1'b0; slow_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d); step(1'b1, d, 1'b0, 1'b0, 1'b0); endtask
    task automatic wstb();                  step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0); endtask
    task automatic wake();                  step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0); endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    endtask
    function automatic int ens();
        return {29'd0, sys_clk_en, main_clk_en, slow_clk_en};
    endfunction

    task automatic t_reset();
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 mode", mode_o, 0);
        check("R1 enables", ens(), 3'b111);
    endtask

    task automatic t_cfg();
        wr(8'hF8);
        check("R2 readback", rd_data, 8'hF8);
        check("R2 no mode change", mode_o, 0);
        wr(8'h50);
        check("R2 readback b", rd_data, 8'h50);
        wr(8'h00);
    endtask

    task automatic t_ps_now();
        wr(8'h01);
        check("R3 not at write", rd_data, 8'h00);
        ticks(LAT - 1);
        check("R3 before last tick", mode_o, 0);
        ticks(1);
        check("R3 mode after ticks", mode_o, 1);
        check("R3 status", rd_data, 8'h01);
        check("R8 ps enables", ens(), 3'b111);
        wr(8'h03);
        check("R10 keep bit stays", mode_o, 1);
        wr(8'h00);
        check("R10 sw clear", mode_o, 0);
    endtask

    task automatic t_ps_defer();
        wr(8'h09);
        ticks(LAT + 1);
        check("R4 pending holds", mode_o, 0);
        wstb();
        ticks(LAT);
        check("R4 deferred entry", mode_o, 1);
        wake();
        check("R9 wake mode", mode_o, 0);
        check("R9 wake status", rd_data, 8'h08);
    endtask

    task automatic t_idle();
        wr(8'h0A);
        check("R8 pending enables", ens(), 3'b111);
        wstb();
        ticks(LAT);
        check("R5 idle entry", mode_o, 2);
        check("R11 idle status", rd_data[2:0], 3'b010);
        check("R8 idle enables", ens(), 3'b011);
        wake();
        wr(8'h02);
        wstb();
        ticks(LAT);
        check("R5 idle without defer ignored", mode_o, 0);
    endtask

    task automatic t_prio();
        wr(8'h0F);
        wstb();
        ticks(LAT);
        check("R6 halt wins", mode_o, 3);
        check("R11 halt status", rd_data[2:0], 3'b100);
        check("R8 halt enables", ens(), 3'b000);
        wake();
        wr(8'h0B);
        wstb();
        ticks(LAT);
        check("R6 idle over ps", mode_o, 2);
        wr(8'h08);
        check("R10 idle sw clear", mode_o, 0);
    endtask

    task automatic t_wait_ignored();
        wr(8'h00);
        wstb();
        ticks(LAT);
        check("R7 stray wait", mode_o, 0);
    endtask

    task automatic t_collisions();
        wr(8'h0A);
        step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
        ticks(LAT);
        check("R9 wake beats wait", mode_o, 0);
        wstb();
        ticks(LAT);
        check("R9 pending cancelled", mode_o, 0);
        wr(8'h01);
        ticks(LAT - 1);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
        check("R9 wake beats done", mode_o, 0);
        ticks(LAT);
        check("R9 switch aborted", mode_o, 0);
        wr(8'h0A);
        wr(8'h08);
        wstb();
        ticks(LAT);
        check("R10 sw cancel pending", mode_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_ps_now();
        t_ps_defer();
        t_idle();
        t_prio();
        t_wait_ignored();
        t_collisions();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule